// File: doc/BRIEF.md
# Burst Address Counter (Linear / Interleaved)

This block produces the two low-order address bits of a four-beat burst. When a burst begins, signalled by either of two active-low start strobes, it captures the low two bits of the external address as the burst base. On each later clock where the active-low advance input is sampled low, it moves to the next word of the four-word block. The order of those words is set by a static order pin: linear wrap-around, or the XOR-based interleaved order.

Internally the block keeps only the captured base and a two-bit beat count. The output offset is formed from the base and the beat count with no clock in between. It is their sum modulo four in linear order and their XOR in interleaved order. The order pin is used without being registered, so a change on it shows on the offset at once. The counter always stays inside the four-word block and never carries into the upper address bits, which lie outside this block.

Top module: `bac_burst_counter`

## Requirements
- R1: While `rst_ni` is low, `offset_o` and `base_o` are both 0.
- R2: On a rising clock edge where `start_proc_ni` or `start_ctrl_ni` is low, `base_o` takes the value of `base_i` and `offset_o` equals `base_i` after that edge, in either order. Either strobe alone is enough.
- R3: With `order_i` = 0 (linear), a rising edge with no start and `advance_ni` low makes `offset_o` = (previous `offset_o` + 1) mod 4. For example, base 2 gives 2,3,0,1.
- R4: With `order_i` = 1 (interleaved), `offset_o` = `base_o` XOR beat. The beat is 0 after a start and increases by 1 mod 4 on each advance. For example, base 1 gives 1,0,3,2.
- R5: On a rising edge with both start strobes high and `advance_ni` high, `offset_o` and `base_o` keep their values.
- R6: When a start strobe and `advance_ni` are both low on the same edge, the start wins: `offset_o` equals the new `base_i` and the beat is 0.
- R7: After four advances from a start, `offset_o` is back at the base, in both orders. Further advances keep cycling inside the same four-word block.
- R8: `order_i` is not registered. Between clock edges, a change on it changes `offset_o` at once: base 1 with beat 1 reads 2 in linear order and 0 in interleaved order.
- R9: `base_o` holds the last captured base across advances and holds, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; everything except `order_i` is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_proc_ni | input | 1 | Burst start strobe, first source, active low |
| start_ctrl_ni | input | 1 | Burst start strobe, second source, active low |
| advance_ni | input | 1 | Step to the next burst word, active low |
| order_i | input | 1 | Burst order, static level: 0 linear, 1 interleaved |
| base_i | input | OFS_W | Low address bits captured on a start |
| offset_o | output | OFS_W | Current low address bits of the burst |
| base_o | output | OFS_W | Base captured at the last start |

## Verification
The case hardest to reach from the ports is a mode change in the middle of a burst. The offset must follow `order_i` with no clock edge, which only shows up when the beat count is neither 0 nor 2. The stimulus therefore starts a burst at base 1 and advances once. It then holds the clock steady and toggles `order_i`, sampling the offset between edges: 2 in linear order, 0 in interleaved order. The wrap back to the base needs a full run of four advances in each order. Start-over-advance priority is reached by driving both strobes low together in the middle of a burst.

// File: rtl/bac_pkg.sv
package bac_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic step;
    } bac_ctl_t;

endpackage

// File: rtl/bac_beat_ctr.sv
module bac_beat_ctr #(
    parameter int OFS_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [OFS_W-1:0] beat_o
);

    typedef struct packed {
        logic [OFS_W-1:0] beat;
    } beat_st_t;

    beat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.beat = '0;
        end else if (step_i) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_o = st_q.beat;

endmodule

// File: rtl/bac_order_map.sv
module bac_order_map
    import bac_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] base_i,
    input  logic [OFS_W-1:0] beat_i,
    input  order_e           order_i,
    output logic [OFS_W-1:0] offset_o
);

    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] ilv_ofs;

    assign lin_ofs = base_i + beat_i;

    for (genvar b = 0; b < OFS_W; b++) begin : g_ilv_bit
        assign ilv_ofs[b] = base_i[b] ^ beat_i[b];
    end

    always_comb begin
        unique case (order_i)
            ORD_INTERLEAVE: offset_o = ilv_ofs;
            default:        offset_o = lin_ofs;
        endcase
    end

endmodule

// File: rtl/bac_burst_counter.sv
module bac_burst_counter
    import bac_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_proc_ni,
    input  logic             start_ctrl_ni,
    input  logic             advance_ni,
    input  logic             order_i,
    input  logic [OFS_W-1:0] base_i,
    output logic [OFS_W-1:0] offset_o,
    output logic [OFS_W-1:0] base_o
);

    typedef struct packed {
        logic [OFS_W-1:0] base;
    } base_st_t;

    bac_ctl_t         ctl;
    base_st_t         st_d, st_q;
    logic [OFS_W-1:0] beat;
    order_e           order;

    // Start from either source wins over advance.
    always_comb begin
        ctl.load = !start_proc_ni || !start_ctrl_ni;
        ctl.step = !ctl.load && !advance_ni;
    end

    always_comb begin
        st_d = st_q;
        if (ctl.load) begin
            st_d.base = base_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bac_beat_ctr #(.OFS_W(OFS_W)) beat_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (ctl.load),
        .step_i  (ctl.step),
        .beat_o  (beat)
    );

    assign order = order_e'(order_i);

    bac_order_map #(.OFS_W(OFS_W)) map_i (
        .base_i   (st_q.base),
        .beat_i   (beat),
        .order_i  (order),
        .offset_o (offset_o)
    );

    assign base_o = st_q.base;

endmodule

// File: rtl/bac_burst_counter_chk.sv
module bac_burst_counter_chk #(
    parameter int OFS_W = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_proc_ni,
    input logic             start_ctrl_ni,
    input logic             advance_ni,
    input logic             order_i,
    input logic [OFS_W-1:0] base_i,
    input logic [OFS_W-1:0] offset_o,
    input logic [OFS_W-1:0] base_o
);

    typedef logic [OFS_W-1:0] ofs_t;

    logic start;
    assign start = !start_proc_ni || !start_ctrl_ni;

    // R1
    always_comb begin
        if (!rst_ni) begin
            reset_zero_chk: assert (offset_o == '0 && base_o == '0);
        end
    end

    // R2
    start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start |=> (base_o == $past(base_i)) && (offset_o == $past(base_i)));

    // R5
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start && advance_ni && $stable(order_i)) |=> ($stable(offset_o) || order_i != $past(order_i)));

    // R3
    linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start && !advance_ni && !order_i) |=> (order_i || offset_o == ofs_t'($past(offset_o) + 1'b1)));

    // R4
    interleave_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start && !advance_ni && order_i) |=>
            (!order_i || (offset_o ^ base_o) == ofs_t'(($past(offset_o) ^ $past(base_o)) + 1'b1)));

    // R6
    start_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start && !advance_ni) |=> (offset_o == $past(base_i)));

    // R9
    base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start |=> $stable(base_o));

endmodule

bind bac_burst_counter bac_burst_counter_chk #(.OFS_W(OFS_W)) chk_i (.*);

// File: tb/bac_burst_counter_tb.sv
module bac_burst_counter_tb_top;

    localparam int W = 2;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         start_proc_ni = 1'b1;
    logic         start_ctrl_ni = 1'b1;
    logic         advance_ni = 1'b1;
    logic         order_i = 1'b0;
    logic [W-1:0] base_i = '0;
    logic [W-1:0] offset_o;
    logic [W-1:0] base_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk_i = ~clk_i;

    bac_burst_counter #(.OFS_W(W)) dut_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_proc_ni (start_proc_ni),
        .start_ctrl_ni (start_ctrl_ni),
        .advance_ni    (advance_ni),
        .order_i       (order_i),
        .base_i        (base_i),
        .offset_o      (offset_o),
        .base_o        (base_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_i);
        #1;
    endtask

    function automatic logic [W-1:0] expect_ofs(input logic ord, input logic [W-1:0] b, input logic [W-1:0] k);
        return ord ? (b ^ k) : W'(b + k);
    endfunction

    task automatic start_burst(input logic use_ctrl, input logic [W-1:0] b);
        base_i = b;
        start_proc_ni = use_ctrl;
        start_ctrl_ni = !use_ctrl;
        tick();
        start_proc_ni = 1'b1;
        start_ctrl_ni = 1'b1;
    endtask

    task automatic t_reset();
        rst_ni = 1'b0;
        #1;
        chk("R1 offset", offset_o, '0);
        chk("R1 base", base_o, '0);
        tick();
        rst_ni = 1'b1;
        tick();
    endtask

    task automatic t_run(input logic ord, input logic use_ctrl, input logic [W-1:0] b);
        order_i = ord;
        start_burst(use_ctrl, b);
        chk("R2 offset after start", offset_o, b);
        chk("R2 base after start", base_o, b);
        for (int k = 1; k <= 4; k++) begin
            advance_ni = 1'b0;
            tick();
            advance_ni = 1'b1;
            if (k < 4) chk(ord ? "R4 interleaved beat" : "R3 linear beat", offset_o, expect_ofs(ord, b, W'(k)));
            else chk("R7 wrap to base", offset_o, b);
            chk("R9 base kept", base_o, b);
        end
        advance_ni = 1'b0;
        tick();
        advance_ni = 1'b1;
        chk("R7 cycle continues", offset_o, expect_ofs(ord, b, 2'd1));
    endtask

    task automatic t_hold();
        order_i = 1'b0;
        start_burst(1'b0, 2'd3);
        advance_ni = 1'b0;
        tick();
        advance_ni = 1'b1;
        tick();
        tick();
        chk("R5 offset held", offset_o, 2'd0);
        chk("R5 base held", base_o, 2'd3);
    endtask

    task automatic t_priority();
        order_i = 1'b1;
        start_burst(1'b0, 2'd2);
        advance_ni = 1'b0;
        tick();
        base_i = 2'd1;
        start_proc_ni = 1'b0;
        start_ctrl_ni = 1'b0;
        tick();
        start_proc_ni = 1'b1;
        start_ctrl_ni = 1'b1;
        chk("R6 start wins offset", offset_o, 2'd1);
        chk("R6 start wins base", base_o, 2'd1);
        tick();
        advance_ni = 1'b1;
        chk("R6 beat restarted", offset_o, 2'd0);
    endtask

    task automatic t_order_comb();
        order_i = 1'b0;
        start_burst(1'b0, 2'd1);
        advance_ni = 1'b0;
        tick();
        advance_ni = 1'b1;
        chk("R8 linear view", offset_o, 2'd2);
        order_i = 1'b1;
        #1;
        chk("R8 interleaved view", offset_o, 2'd0);
        order_i = 1'b0;
        #1;
        chk("R8 back to linear", offset_o, 2'd2);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_run(1'b0, 1'b0, 2'd2);
        t_run(1'b1, 1'b1, 2'd1);
        t_run(1'b0, 1'b1, 2'd0);
        t_run(1'b1, 1'b0, 2'd3);
        t_hold();
        t_priority();
        t_order_comb();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule